// File: doc/BRIEF.md
# Second-Level Cache Tag Lookup Controller

This controller runs the tag side of an external, direct-mapped second-level cache built from standard synchronous SRAM. The cache holds one 128-bit quadword per index. Each request gives a quadword-granular physical address and says whether it is an instruction or a data access. The controller forms the SRAM index from the low address bits and enables the tag SRAM output for that read. When the tag word comes back, it recomputes the tag's check bits and compares the stored address tag with the request. It then reports hit, miss or tag error.

Size and organisation are set per request. A 3-bit size code selects a total size from 128 KB (code 0) to 4 MB (code 5). A split flag divides the array into an instruction half and a data half. A new request can be accepted every cycle, and results come out in request order at a fixed latency.

Top module: `l2_tag_lookup`

## Requirements
- R1: While rst_ni is low, and afterwards until a request reaches the output, sram_oe_o, resp_valid_o, hit_o and tag_err_o are all 0. hit_o and tag_err_o are never 1 while resp_valid_o is 0.
- R2: sram_oe_o is 1 in exactly the cycle that follows a cycle with req_valid_i high, and 0 in every other cycle. sram_index_o holds that request's index while sram_oe_o is 1.
- R3: In joint mode (cfg_split_i = 0) with size code s, the index width is n = 13 + s. sram_index_o equals the low n bits of req_qaddr_i, and all index bits at n and above are 0.
- R4: Size codes 6 and 7 behave exactly like code 5 (4 MB, n = 18).
- R5: In split mode (cfg_split_i = 1), index bit n-1 equals req_instr_i: 1 selects the instruction half and 0 the data half. Index bits n-2..0 come from req_qaddr_i.
- R6: In split mode, size code 0 is treated as code 1 (256 KB, n = 14), so each half holds at least 128 KB.
- R7: The 32-bit tag word has this layout: bits [18:0] hold the stored address tag; bits [23:19] are state bits that are never compared; bit 24 is the valid bit; bits [31:25] hold the check bits. The result is a hit when the valid bit is set, the check bits agree, and bits [18:0] equal req_qaddr_i[31:13] in every position at or above k. Here k = s in joint mode and k = s - 1 in split mode, using the effective s from R4 and R6.
- R8: The expected check bit c, for c = 0..6, is the XOR of all tag bits j in [24:0] with j mod 7 = c. If any stored check bit differs from its expected value, tag_err_o = 1 and hit_o = 0 for that response.
- R9: resp_valid_o is 1 exactly three cycles after the cycle in which a request was sampled, once per request. Back-to-back requests give back-to-back responses in request order. The tag word is read from tag_rd_data_i one cycle after sram_oe_o.
- R10: An entry whose valid bit is 0 gives a miss without a tag error, even when its address tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_size_i | input | 3 | Total size code, 128 KB shifted left by the code |
| cfg_split_i | input | 1 | 1 = separate instruction and data halves |
| req_valid_i | input | 1 | Lookup request |
| req_qaddr_i | input | 32 | Physical address bits 35..4 (quadword address) |
| req_instr_i | input | 1 | 1 = instruction access, 0 = data access |
| sram_index_o | output | 18 | Tag SRAM index |
| sram_oe_o | output | 1 | Tag SRAM output enable (read cycle) |
| tag_rd_data_i | input | 32 | Tag word returned by the SRAM, one cycle after enable |
| resp_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Tag matched and entry is valid and intact |
| tag_err_o | output | 1 | Check bits of the tag word disagree |

## Verification
A wrong index is visible on sram_index_o in the cycle after the request. Because the bench SRAM model then returns a different entry's word, a wrong index also shows up two cycles later as a wrong hit. A mask count that is off by one lets a differing tag bit through, or blocks a matching one, at the boundary bit. The bench targets that boundary directly for both joint and split organisations. A pipeline slip or a lost valid shows up as resp_valid_o in the wrong cycle, because the reference model compares every cycle against the exact due time.

// File: rtl/l2t_pkg.sv
package l2t_pkg;
  localparam int unsigned PA_W      = 36;
  localparam int unsigned OFF_W     = 4;   // byte offset inside a quadword
  localparam int unsigned MIN_IDX_W = 13;  // 128 KB / 16 B
  localparam int unsigned N_SIZES   = 6;   // 128 KB .. 4 MB
  localparam int unsigned SZ_W      = 3;
  localparam int unsigned TAG_W     = 25;
  localparam int unsigned CHK_W     = 7;
  localparam int unsigned QA_W      = PA_W - OFF_W;
  localparam int unsigned IDX_W     = MIN_IDX_W + N_SIZES - 1;
  localparam int unsigned ATAG_W    = QA_W - MIN_IDX_W;
  localparam int unsigned WORD_W    = TAG_W + CHK_W;

  typedef struct packed {
    logic              vld;
    logic [ATAG_W-1:0] atag;
    logic [SZ_W-1:0]   mcnt;
  } l2t_stage_t;
endpackage

// File: rtl/l2t_index.sv
module l2t_index
  import l2t_pkg::*;
#(
  parameter int unsigned IW   = IDX_W,
  parameter int unsigned MINW = MIN_IDX_W,
  parameter int unsigned NSZ  = N_SIZES,
  parameter int unsigned SW   = SZ_W
) (
  input  logic [SW-1:0] size_i,
  input  logic          split_i,
  input  logic [IW-1:0] addr_i,
  input  logic          instr_i,
  output logic [IW-1:0] idx_o,
  output logic [SW-1:0] mcnt_o
);
  localparam int MAX_CODE = NSZ - 1;

  int s_eff;
  int n_bits;

  always_comb begin
    s_eff = int'(size_i);
    if (s_eff > MAX_CODE) s_eff = MAX_CODE;
    if (split_i && s_eff == 0) s_eff = 1;
    n_bits = int'(MINW) + s_eff;
    mcnt_o = split_i ? SW'(s_eff - 1) : SW'(s_eff);
  end

  for (genvar i = 0; i < IW; i++) begin : g_bit
    assign idx_o[i] = (i < n_bits) &&
                      ((split_i && (i == n_bits - 1)) ? instr_i : addr_i[i]);
  end
endmodule

// File: rtl/l2t_chk.sv
module l2t_chk #(
  parameter int unsigned DW = 25,
  parameter int unsigned CW = 7
) (
  input  logic [DW-1:0] d_i,
  output logic [CW-1:0] c_o
);
  always_comb begin
    c_o = '0;
    for (int j = 0; j < int'(DW); j++) c_o[j % CW] = c_o[j % CW] ^ d_i[j];
  end
endmodule

// File: rtl/l2t_cmp.sv
module l2t_cmp
  import l2t_pkg::*;
#(
  parameter int unsigned TW = TAG_W,
  parameter int unsigned CW = CHK_W,
  parameter int unsigned AW = ATAG_W,
  parameter int unsigned SW = SZ_W
) (
  input  logic [TW+CW-1:0] word_i,
  input  logic [AW-1:0]    atag_i,
  input  logic [SW-1:0]    mcnt_i,
  output logic             hit_o,
  output logic             err_o
);
  logic [CW-1:0] chk_calc;
  logic [AW-1:0] diff_m;

  l2t_chk #(.DW(TW), .CW(CW)) u_chk (
    .d_i (word_i[TW-1:0]),
    .c_o (chk_calc)
  );

  // low bits that sit inside the index are excluded from the compare
  for (genvar i = 0; i < AW; i++) begin : g_cmp
    assign diff_m[i] = (word_i[i] ^ atag_i[i]) && (i >= int'(mcnt_i));
  end

  assign err_o = chk_calc != word_i[TW +: CW];
  assign hit_o = word_i[TW-1] && (diff_m == '0) && !err_o;
endmodule

// File: rtl/l2_tag_lookup.sv
module l2_tag_lookup
  import l2t_pkg::*;
#(
  parameter int unsigned QAW  = QA_W,
  parameter int unsigned IW   = IDX_W,
  parameter int unsigned SW   = SZ_W,
  parameter int unsigned WW   = WORD_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [SW-1:0]  cfg_size_i,
  input  logic           cfg_split_i,
  input  logic           req_valid_i,
  input  logic [QAW-1:0] req_qaddr_i,
  input  logic           req_instr_i,
  output logic [IW-1:0]  sram_index_o,
  output logic           sram_oe_o,
  input  logic [WW-1:0]  tag_rd_data_i,
  output logic           resp_valid_o,
  output logic           hit_o,
  output logic           tag_err_o
);
  logic [IW-1:0] idx_c;
  logic [SW-1:0] mcnt_c;
  logic          hit_c, err_c;
  l2t_stage_t    s1_q, s2_q;

  l2t_index u_index (
    .size_i  (cfg_size_i),
    .split_i (cfg_split_i),
    .addr_i  (req_qaddr_i[IW-1:0]),
    .instr_i (req_instr_i),
    .idx_o   (idx_c),
    .mcnt_o  (mcnt_c)
  );

  // stage 1: drive the tag SRAM read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q         <= '0;
      sram_index_o <= '0;
      sram_oe_o    <= 1'b0;
    end else begin
      s1_q.vld  <= req_valid_i;
      sram_oe_o <= req_valid_i;
      if (req_valid_i) begin
        s1_q.atag    <= req_qaddr_i[QAW-1 -: ATAG_W];
        s1_q.mcnt    <= mcnt_c;
        sram_index_o <= idx_c;
      end
    end
  end

  // stage 2: wait for SRAM data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_q <= '0;
    else         s2_q <= s1_q;
  end

  l2t_cmp u_cmp (
    .word_i (tag_rd_data_i),
    .atag_i (s2_q.atag),
    .mcnt_i (s2_q.mcnt),
    .hit_o  (hit_c),
    .err_o  (err_c)
  );

  // stage 3: registered result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      hit_o        <= 1'b0;
      tag_err_o    <= 1'b0;
    end else begin
      resp_valid_o <= s2_q.vld;
      hit_o        <= s2_q.vld && hit_c;
      tag_err_o    <= s2_q.vld && err_c;
    end
  end

  a_r2_oe_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> sram_oe_o);
  a_r2_oe_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !sram_oe_o);
  a_r9_resp_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_oe_o |-> ##2 resp_valid_o);
  a_r9_no_stray_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_o |-> ##2 !resp_valid_o);
  a_r8_err_is_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_err_o |-> resp_valid_o && !hit_o);
  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !hit_o && !tag_err_o);
endmodule

// File: tb/tb_l2_tag_lookup.sv
module tb_l2_tag_lookup;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_ni = 0;
  logic [2:0]  cfg_size = 0;
  logic        cfg_split = 0;
  logic        req_valid = 0;
  logic [31:0] req_qaddr = 0;
  logic        req_instr = 0;
  logic [17:0] sram_index;
  logic        sram_oe;
  logic [31:0] tag_rd_data = 0;
  logic        resp_valid, hit, tag_err;

  l2_tag_lookup dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_size_i(cfg_size), .cfg_split_i(cfg_split),
    .req_valid_i(req_valid), .req_qaddr_i(req_qaddr), .req_instr_i(req_instr),
    .sram_index_o(sram_index), .sram_oe_o(sram_oe), .tag_rd_data_i(tag_rd_data),
    .resp_valid_o(resp_valid), .hit_o(hit), .tag_err_o(tag_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [31:0] mem [int];

  // SRAM model: one cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sram_oe) tag_rd_data <= mem.exists(int'(sram_index)) ? mem[int'(sram_index)] : 32'h0;
  end

  // expectation queues
  int    oe_due[$];  int oe_idx[$];
  int    rs_due[$];  bit rs_hit[$]; bit rs_err[$]; string rs_tag[$];

  task automatic check(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      check(!sram_oe && !resp_valid && !hit && !tag_err, "R1", "reset outputs",
            {sram_oe, resp_valid, hit, tag_err}, 0);
    end else begin
      if (oe_due.size() > 0 && oe_due[0] == cyc) begin
        check(sram_oe == 1, "R2", "oe", sram_oe, 1);
        check(int'(sram_index) == oe_idx[0], "R3/R5 index", "index", sram_index, oe_idx[0]);
        void'(oe_due.pop_front()); void'(oe_idx.pop_front());
      end else check(sram_oe == 0, "R2", "oe idle", sram_oe, 0);
      if (rs_due.size() > 0 && rs_due[0] == cyc) begin
        check(resp_valid == 1, "R9", "resp_valid", resp_valid, 1);
        check(hit == rs_hit[0], rs_tag[0], "hit", hit, rs_hit[0]);
        check(tag_err == rs_err[0], rs_tag[0], "tag_err", tag_err, rs_err[0]);
        void'(rs_due.pop_front()); void'(rs_hit.pop_front());
        void'(rs_err.pop_front()); void'(rs_tag.pop_front());
      end else begin
        check(resp_valid == 0, "R9", "resp idle", resp_valid, 0);
        check(!hit && !tag_err, "R1", "result idle", {hit, tag_err}, 0);
      end
    end
  end

  function automatic int eff_s(input int code, input bit split);
    int s = (code > 5) ? 5 : code;
    if (split && s == 0) s = 1;
    return s;
  endfunction

  function automatic int exp_idx(input logic [31:0] qa, input int code, input bit split, input bit instr);
    int n = 13 + eff_s(code, split);
    int v = int'(qa) & ((1 << n) - 1);
    if (split) v = instr ? (v | (1 << (n - 1))) : (v & ~(1 << (n - 1)));
    return v;
  endfunction

  function automatic logic [6:0] chk_of(input logic [24:0] t);
    logic [6:0] c = 0;
    for (int j = 0; j < 25; j++) c[j % 7] ^= t[j];
    return c;
  endfunction

  task automatic put(input int idx, input bit vld, input logic [4:0] st,
                     input logic [18:0] at, input logic [6:0] flip);
    logic [24:0] t = {vld, st, at};
    mem[idx] = {chk_of(t) ^ flip, t};
  endtask

  task automatic req(input logic [31:0] qa, input int code, input bit split,
                     input bit instr, input string rq);
    int idx; logic [31:0] w; bit err, h; int k;
    @(negedge clk);
    cfg_size = 3'(code); cfg_split = split; req_qaddr = qa; req_instr = instr; req_valid = 1;
    idx = exp_idx(qa, code, split, instr);
    w = mem.exists(idx) ? mem[idx] : 32'h0;
    err = chk_of(w[24:0]) != w[31:25];
    k = split ? eff_s(code, split) - 1 : eff_s(code, split);
    h = !err && w[24] && (((w[18:0] ^ qa[31:13]) >> k) == 0);
    oe_due.push_back(cyc + 1); oe_idx.push_back(idx);
    rs_due.push_back(cyc + 3); rs_hit.push_back(h); rs_err.push_back(err); rs_tag.push_back(rq);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); req_valid = 0; end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] qa;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R3/R7 joint 128 KB: match and upper-bit mismatch
    qa = 32'h0ABC_1234;
    put(exp_idx(qa, 0, 0, 0), 1, 5'h0, qa[31:13], 0);
    req(qa, 0, 0, 0, "R7 joint hit"); idle(4);
    req(qa ^ 32'h0010_0000, 0, 0, 0, "R7 upper mismatch"); idle(4);
    // R7 masked bits with code 2: low 2 tag bits ignored, bit 2 compared
    qa = 32'h1357_9BDF;
    put(exp_idx(qa, 2, 0, 0), 1, 5'h0, qa[31:13] ^ 19'h3, 0);
    req(qa, 2, 0, 0, "R7 masked low bits hit"); idle(4);
    put(exp_idx(qa, 2, 0, 0), 1, 5'h0, qa[31:13] ^ 19'h4, 0);
    req(qa, 2, 0, 0, "R7 boundary bit miss"); idle(4);
    // R7 state bits ignored
    put(exp_idx(qa, 2, 0, 0), 1, 5'h1F, qa[31:13], 0);
    req(qa, 2, 0, 0, "R7 state bits ignored"); idle(4);
    // R4 clamp
    qa = 32'hFEDC_BA98;
    put(exp_idx(qa, 5, 0, 0), 1, 5'h2, qa[31:13] ^ 19'h1F, 0);
    req(qa, 7, 0, 0, "R4 code7 as code5"); idle(4);
    req(qa, 6, 0, 0, "R4 code6 as code5"); idle(4);
    // R5 split halves
    qa = 32'h0246_8ACE;
    put(exp_idx(qa, 3, 1, 1), 1, 5'h0, qa[31:13] ^ 19'h3, 0);
    put(exp_idx(qa, 3, 1, 0), 1, 5'h0, qa[31:13] ^ 19'h4, 0);
    req(qa, 3, 1, 1, "R5 split instr hit"); idle(4);
    req(qa, 3, 1, 0, "R5 split data boundary miss"); idle(4);
    // R6 split minimum size
    qa = 32'h0000_3FFF;
    put(exp_idx(qa, 0, 1, 1), 1, 5'h0, qa[31:13], 0);
    req(qa, 0, 1, 1, "R6 split code0 hit"); idle(4);
    req(qa ^ 32'h0000_2000, 0, 1, 1, "R6 split code0 addr bit13 miss"); idle(4);
    // R10 invalid entry
    qa = 32'h0770_0770;
    put(exp_idx(qa, 1, 0, 0), 0, 5'h0, qa[31:13], 0);
    req(qa, 1, 0, 0, "R10 invalid miss"); idle(4);
    // R8 corrupted check bits
    put(exp_idx(qa, 1, 0, 0), 1, 5'h0, qa[31:13], 7'h01);
    req(qa, 1, 0, 0, "R8 check error"); idle(4);
    put(exp_idx(qa, 1, 0, 0), 1, 5'h0, qa[31:13], 7'h40);
    req(qa, 1, 0, 0, "R8 check error bit6"); idle(4);
    // R9 back-to-back burst with mixed configurations
    for (int i = 0; i < 12; i++) begin
      logic [31:0] a = 32'h1000_0000 + 32'(i) * 32'h0013_5791;
      put(exp_idx(a, i % 8, i[0], i[1]), i % 5 != 0, 5'(i), a[31:13] ^ 19'(i % 3), 7'(i == 7));
    end
    for (int i = 0; i < 12; i++) begin
      logic [31:0] a = 32'h1000_0000 + 32'(i) * 32'h0013_5791;
      req(a, i % 8, i[0], i[1], "R9 burst");
    end
    idle(6);
    done = 1;
    finish_run();
  end
endmodule